// File: doc/BRIEF.md
# Scrollable Bitmap Display Memory

This block is a pixel memory with one bit per pixel, 128 columns wide and 65 rows tall. It sits between a host port and a panel scan engine. The host addresses the memory by page (a band of eight rows) and column. Each byte written or read covers eight vertically stacked pixels of one column. After every byte access the column pointer advances by one, so a whole page can be streamed with a single address load.

The scan side presents a common row index and receives that line's pixels as one 128-bit vector. Two independent mirror controls shape the scan mapping. The row mirror reverses the order of the display lines. The column mirror reverses the pixel order within a line. A start-line offset is then added modulo 65, which scrolls the picture vertically without moving any stored data. Host accesses always use the unmirrored, unscrolled addressing.

Top module: `dispram_scroll`

## Requirements
- R1: A host write stores data bit k (bit 0 is the least significant) at row 8*page+k of the current column.
- R2: A host read returns the byte of the current page and column on `hst_rdata` one clock after it is sampled, using the same bit-to-row order as R1. `hst_rdata` holds its value in every cycle without a read.
- R3: Each accepted write or read advances the column pointer by one, wrapping from 127 to 0. The page is unchanged.
- R4: Page 8 stores only data bit 0 (row 64), and its reads return 0 in bits 7:1. Pages 9 to 15 store nothing and read as 0.
- R5: One clock after `scan_row` is sampled, `pix_line` carries RAM row (start_line + line) mod 65. Here line is `scan_row` when the row mirror is off, and `pix_line[c]` is column c.
- R6: Scrolling wraps: with start line 56, line 0 shows RAM row 56 and line 9 shows RAM row 0.
- R7: With `seg_rev` high, `pix_line[c]` carries column 127-c of the selected row.
- R8: With `com_rev` high, line is 64 - `scan_row` before the start-line offset is applied.
- R9: `hst_ld` loads the page and column pointers. A write or read strobe in the same cycle is ignored.
- R10: Synchronous active-low reset clears `hst_rdata`, `pix_line`, the page and the column to zero. It leaves the memory contents intact.
- R11: A scan read in the same cycle as a host write to that row returns the contents from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hst_ld | input | 1 | Load page and column pointers |
| hst_ld_page | input | 4 | Page value to load |
| hst_ld_col | input | 7 | Column value to load |
| hst_we | input | 1 | Write byte at pointer (takes priority over hst_re) |
| hst_re | input | 1 | Read byte at pointer |
| hst_wdata | input | 8 | Write byte |
| hst_rdata | output | 8 | Read byte, registered |
| start_line | input | 7 | Scroll offset, 0 to 64 |
| seg_rev | input | 1 | Column mirror on scan output |
| com_rev | input | 1 | Row mirror on scan lines |
| scan_row | input | 7 | Display line being scanned, 0 to 64 |
| pix_line | output | 128 | Pixels of the scanned line, registered |

## Verification
Both outputs are single-register results. `hst_rdata` changes at the edge that samples a read, and `pix_line` changes at the edge that samples `scan_row`, the mirror bits and the start line. A host write becomes visible to host reads and to the scan from the next edge onward. The bench changes inputs only after a falling edge. Its reference model advances at each rising edge from the inputs it saw. Both outputs are compared with the model at every falling edge, so each result is checked in exactly the cycle it is due. The pixel comparison starts only once the whole memory has been written through the host port.

// File: rtl/dispram_pkg.sv
// Shared definitions for the scrollable bitmap memory.
// Assumes byte-wide host access, with one byte covering eight rows of a column.
package dispram_pkg;
    localparam int BYTE_BITS = 8;

    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_READ  = 2'd2
    } host_acc_e;
endpackage

// File: rtl/dispram_host_ptr.sv
// Host address pointer: decodes the strobes into one access per cycle and
// keeps the page and column registers.
// Assumes COLS <= 2**COL_W. A pointer load suppresses same-cycle strobes.
module dispram_host_ptr
    import dispram_pkg::*;
#(
    parameter int COLS  = 128,
    parameter int COL_W = 7,
    parameter int PG_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld,
    input  logic [PG_W-1:0]  ld_page,
    input  logic [COL_W-1:0] ld_col,
    input  logic             we,
    input  logic             re,
    output host_acc_e        acc,
    output logic [PG_W-1:0]  page,
    output logic [COL_W-1:0] col
);
    localparam logic [COL_W-1:0] COL_LAST = COL_W'(COLS - 1);

    // Pick the single access performed this cycle.
    always_comb begin
        if (ld)      acc = ACC_IDLE;
        else if (we) acc = ACC_WRITE;
        else if (re) acc = ACC_READ;
        else         acc = ACC_IDLE;
    end

    // Load or advance the pointers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page <= '0;
            col  <= '0;
        end else if (ld) begin
            page <= ld_page;
            col  <= ld_col;
        end else if (acc != ACC_IDLE) begin
            col <= (col == COL_LAST) ? '0 : col + 1'b1;
        end
    end

    // R3: wrap from the last column
    a_r3_col_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld && (we || re) && col == COL_LAST) |=> (col == '0));

    // R3: step by one elsewhere
    a_r3_col_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld && (we || re) && col != COL_LAST) |=> (col == $past(col) + 1'b1));

    // R3: page only changes on a load
    a_r3_page_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld) |=> $stable(page));

    // R9: load takes the presented values
    a_r9_ld_take: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> (page == $past(ld_page) && col == $past(ld_col)));
endmodule

// File: rtl/dispram_scan_map.sv
// Scan row mapper: optional line mirror, then start-line offset modulo ROWS.
// Assumes start_line and scan_row both lie in 0..ROWS-1.
module dispram_scan_map #(
    parameter int ROWS  = 65,
    parameter int ROW_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ROW_W-1:0] start_line,
    input  logic             com_rev,
    input  logic [ROW_W-1:0] scan_row,
    output logic [ROW_W-1:0] ram_row
);
    localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(ROWS - 1);
    localparam logic [ROW_W:0]   ROWS_X   = (ROW_W + 1)'(ROWS);

    logic [ROW_W-1:0] line;
    logic [ROW_W:0]   sum;

    // Mirror the line, add the offset and fold back into range.
    always_comb begin
        line    = com_rev ? (ROW_LAST - scan_row) : scan_row;
        sum     = {1'b0, start_line} + {1'b0, line};
        ram_row = (sum >= ROWS_X) ? ROW_W'(sum - ROWS_X) : sum[ROW_W-1:0];
    end

    // R5: mapped row stays inside the memory
    a_r5_row_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (start_line <= ROW_LAST && scan_row <= ROW_LAST) |-> (ram_row <= ROW_LAST));

    // R8: mirrored first line with no offset is the last row
    a_r8_mirror_first: assert property (@(posedge clk) disable iff (!rst_n)
        (com_rev && scan_row == '0 && start_line == '0) |-> (ram_row == ROW_LAST));
endmodule

// File: rtl/dispram_scroll.sv
// Scrollable bitmap display memory, one bit per pixel.
// Host side: byte access by page and column with column auto-increment.
// Scan side: one registered line of pixels, with start-line scrolling and
// independent row and column mirroring. Scan reads see pre-write contents.
// Assumes 8*2**PG_W >= ROWS.
module dispram_scroll
    import dispram_pkg::*;
#(
    parameter int COLS = 128,
    parameter int ROWS = 65,
    parameter int PG_W = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     hst_ld,
    input  logic [PG_W-1:0]          hst_ld_page,
    input  logic [$clog2(COLS)-1:0]  hst_ld_col,
    input  logic                     hst_we,
    input  logic                     hst_re,
    input  logic [7:0]               hst_wdata,
    output logic [7:0]               hst_rdata,
    input  logic [$clog2(ROWS)-1:0]  start_line,
    input  logic                     seg_rev,
    input  logic                     com_rev,
    input  logic [$clog2(ROWS)-1:0]  scan_row,
    output logic [COLS-1:0]          pix_line
);
    localparam int COL_W = $clog2(COLS);
    localparam int ROW_W = $clog2(ROWS);
    localparam int IX_W  = PG_W + 3;
    localparam int PAGES = (ROWS + BYTE_BITS - 1) / BYTE_BITS;
    localparam logic [IX_W-1:0]  ROWS_IX   = IX_W'(ROWS);
    localparam logic [ROW_W-1:0] ROWS_R    = ROW_W'(ROWS);
    localparam logic [PG_W-1:0]  PAGES_P   = PG_W'(PAGES);
    localparam logic [7:0]       LAST_MASK = 8'((1 << (ROWS - BYTE_BITS * (PAGES - 1))) - 1);

    host_acc_e        acc;
    logic [PG_W-1:0]  page;
    logic [COL_W-1:0] col;
    logic [ROW_W-1:0] ram_row;

    logic [IX_W-1:0]  row_ix [BYTE_BITS];
    logic [BYTE_BITS-1:0] row_ok;
    logic [7:0]       rd_byte;
    logic [COLS-1:0]  scan_bits;
    logic [COLS-1:0]  scan_rev;
    logic [COLS-1:0]  mem [ROWS];

    dispram_host_ptr #(.COLS(COLS), .COL_W(COL_W), .PG_W(PG_W)) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld      (hst_ld),
        .ld_page (hst_ld_page),
        .ld_col  (hst_ld_col),
        .we      (hst_we),
        .re      (hst_re),
        .acc     (acc),
        .page    (page),
        .col     (col)
    );

    dispram_scan_map #(.ROWS(ROWS), .ROW_W(ROW_W)) u_map (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_line (start_line),
        .com_rev    (com_rev),
        .scan_row   (scan_row),
        .ram_row    (ram_row)
    );

    // Row index and validity of each bit of the host byte.
    for (genvar b = 0; b < BYTE_BITS; b++) begin : g_bit
        assign row_ix[b]  = {page, 3'(b)};
        assign row_ok[b]  = row_ix[b] < ROWS_IX;
        assign rd_byte[b] = row_ok[b] ? mem[row_ix[b][ROW_W-1:0]][col] : 1'b0;
    end

    // Column-mirrored copy of the scanned row.
    for (genvar c = 0; c < COLS; c++) begin : g_rev
        assign scan_rev[c] = scan_bits[COLS-1-c];
    end

    assign scan_bits = (ram_row < ROWS_R) ? mem[ram_row] : '0;

    // Store the in-range bits of a host byte.
    always_ff @(posedge clk) begin
        if (acc == ACC_WRITE) begin
            for (int b = 0; b < BYTE_BITS; b++) begin
                if (row_ok[b]) mem[row_ix[b][ROW_W-1:0]][col] <= hst_wdata[b];
            end
        end
    end

    // Register the host read byte and the scan line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hst_rdata <= '0;
            pix_line  <= '0;
        end else begin
            pix_line <= seg_rev ? scan_rev : scan_bits;
            if (acc == ACC_READ) hst_rdata <= rd_byte;
        end
    end

    // R2: read data holds without a read
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (acc != ACC_READ) |=> $stable(hst_rdata));

    // R4: partial page returns no bits above the last row
    a_r4_partial_page: assert property (@(posedge clk) disable iff (!rst_n)
        (acc == ACC_READ && page == PAGES_P - 1'b1) |=> ((hst_rdata & ~LAST_MASK) == 8'h00));

    // R4: pages past the end read as zero
    a_r4_beyond_end: assert property (@(posedge clk) disable iff (!rst_n)
        (acc == ACC_READ && page >= PAGES_P) |=> (hst_rdata == 8'h00));
endmodule

// File: tb/dispram_scroll_bench.sv
module dispram_scroll_bench;
    localparam int COLS = 128;
    localparam int ROWS = 65;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         hst_ld;
    logic [3:0]   hst_ld_page;
    logic [6:0]   hst_ld_col;
    logic         hst_we;
    logic         hst_re;
    logic [7:0]   hst_wdata;
    logic [7:0]   hst_rdata;
    logic [6:0]   start_line;
    logic         seg_rev;
    logic         com_rev;
    logic [6:0]   scan_row;
    logic [127:0] pix_line;

    always #10 clk = ~clk;

    dispram_scroll u_dispram_scroll (
        .clk(clk), .rst_n(rst_n), .hst_ld(hst_ld), .hst_ld_page(hst_ld_page),
        .hst_ld_col(hst_ld_col), .hst_we(hst_we), .hst_re(hst_re),
        .hst_wdata(hst_wdata), .hst_rdata(hst_rdata), .start_line(start_line),
        .seg_rev(seg_rev), .com_rev(com_rev), .scan_row(scan_row), .pix_line(pix_line)
    );

    // Behavioural reference model
    bit           refm [ROWS][COLS];
    logic [7:0]   m_rdata;
    logic [127:0] m_pix;
    int           m_col, m_page;
    int           n_cmp = 0, n_bad = 0;
    string        tag = "R10";
    bit           filled = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_rdata = '0; m_pix = '0; m_col = 0; m_page = 0;
        end else begin
            int line, r;
            line = com_rev ? (ROWS - 1 - int'(scan_row)) : int'(scan_row);
            r = (int'(start_line) + line) % ROWS;
            for (int c = 0; c < COLS; c++)
                m_pix[c] = seg_rev ? refm[r][COLS-1-c] : refm[r][c];
            if (hst_ld) begin
                m_page = int'(hst_ld_page); m_col = int'(hst_ld_col);
            end else if (hst_we) begin
                for (int k = 0; k < 8; k++)
                    if (m_page * 8 + k < ROWS) refm[m_page*8+k][m_col] = hst_wdata[k];
                m_col = (m_col + 1) % COLS;
            end else if (hst_re) begin
                for (int k = 0; k < 8; k++)
                    m_rdata[k] = (m_page * 8 + k < ROWS) ? refm[m_page*8+k][m_col] : 1'b0;
                m_col = (m_col + 1) % COLS;
            end
        end
    end

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        n_cmp++;
        if (hst_rdata !== m_rdata) begin
            n_bad++;
            $display("FAIL %s hst_rdata: actual %02h expected %02h", tag, hst_rdata, m_rdata);
        end
        if (filled) begin
            n_cmp++;
            if (pix_line !== m_pix) begin
                n_bad++;
                $display("FAIL %s pix_line: actual %032h expected %032h", tag, pix_line, m_pix);
            end
        end
    endtask

    task automatic load(int p, int c);
        hst_ld = 1'b1; hst_ld_page = 4'(p); hst_ld_col = 7'(c);
        step();
        hst_ld = 1'b0;
    endtask

    task automatic wr(logic [7:0] d);
        hst_we = 1'b1; hst_wdata = d;
        step();
        hst_we = 1'b0;
    endtask

    task automatic rd();
        hst_re = 1'b1;
        step();
        hst_re = 1'b0;
    endtask

    task automatic sweep();
        for (int r = 0; r < ROWS; r++) begin
            scan_row = 7'(r);
            step();
        end
    endtask

    function automatic logic [7:0] pat(int p, int c);
        return 8'(p * 37 + c * 11 + 5);
    endfunction

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        rst_n = 1'b0; hst_ld = 1'b0; hst_ld_page = '0; hst_ld_col = '0;
        hst_we = 1'b0; hst_re = 1'b0; hst_wdata = '0;
        start_line = '0; seg_rev = 1'b0; com_rev = 1'b0; scan_row = '0;
        // R10: reset values of read data
        tag = "R10";
        repeat (3) step();
        rst_n = 1'b1;
        step();

        // R1: fill the whole memory through the host port
        tag = "R1";
        for (int p = 0; p < 9; p++) begin
            load(p, 0);
            for (int c = 0; c < COLS; c++) wr(pat(p, c));
        end
        step();
        filled = 1;
        step();

        // R10: reset clears pointers and pixel output, keeps memory
        tag = "R10";
        load(4, 77);
        rst_n = 1'b0;
        step();
        rst_n = 1'b1;
        rd();
        step();

        // R2: stream reads and hold
        tag = "R2";
        load(3, 0);
        for (int c = 0; c < COLS; c++) rd();
        repeat (3) step();

        // R3: wrap of the column pointer on reads and writes
        tag = "R3";
        load(5, 126);
        repeat (4) rd();
        load(1, 127);
        wr(8'h3C);
        rd();
        load(1, 127);
        rd();

        // R4: partial page and pages past the end
        tag = "R4";
        load(8, 0);
        repeat (10) rd();
        load(9, 5);
        wr(8'hFF);
        load(9, 5);
        rd();
        load(15, 0);
        wr(8'hFF);
        load(15, 0);
        rd();

        // R5: plain scan mapping
        tag = "R5";
        start_line = 7'd0;  sweep();
        start_line = 7'd20; sweep();

        // R6: wrap-around scrolling
        tag = "R6";
        start_line = 7'd56; sweep();
        start_line = 7'd64; sweep();

        // R7: column mirror
        tag = "R7";
        seg_rev = 1'b1; start_line = 7'd0; sweep();
        seg_rev = 1'b0;

        // R8: row mirror, alone and with the column mirror
        tag = "R8";
        com_rev = 1'b1; start_line = 7'd0;  sweep();
        start_line = 7'd10; sweep();
        seg_rev = 1'b1; sweep();
        seg_rev = 1'b0; com_rev = 1'b0; start_line = 7'd0;

        // R9: load with a write strobe, then with a read strobe
        tag = "R9";
        hst_ld = 1'b1; hst_ld_page = 4'd2; hst_ld_col = 7'd3; hst_we = 1'b1; hst_wdata = 8'h00;
        step();
        hst_ld = 1'b0; hst_we = 1'b0;
        rd();
        hst_ld = 1'b1; hst_ld_page = 4'd6; hst_ld_col = 7'd9; hst_re = 1'b1;
        step();
        hst_ld = 1'b0; hst_re = 1'b0;
        step();
        rd();

        // R11: scan during a write to the scanned row shows old data first
        tag = "R11";
        scan_row = 7'd0;
        load(0, 0);
        wr(8'h00);
        step();
        step();

        summary();
        $finish;
    end
endmodule